// File: doc/BRIEF.md
# Cubic Polynomial Chirp Phase Generator

This block produces the instantaneous phase of a chirp whose phase is a third-order polynomial in sample time. Three adder-and-register sections are chained, and all of them are clocked at the sample rate. The innermost section adds a constant cubic increment to a chirp-rate register. The middle section adds the chirp rate to a frequency register. The outer section adds the frequency to the phase register. All values are fixed-point integers scaled by 2^ACC_W. The binary point sits just above the most significant bit, so one full register range is one rotation, and arithmetic overflow wraps modulo one cycle.

Before a chirp, four coefficient values are written through a simple strobe-and-index port. These are the start phase, the start frequency, the start chirp rate and the cubic increment. A start strobe then copies them into the working sections and produces one phase word per clock for a programmed number of samples. The word is the truncated upper bits of the phase register, which feed a later angle-to-amplitude stage. Between chirps the coefficients may be rewritten, for example to follow temperature drift. A start phase of three quarters of a rotation places a rising cosine zero crossing exactly at the first sample.

Top module: `cubic_phase_gen`

## Requirements
- R1: After reset, busy and phase_valid are low and phase_out is zero.
- R2: A write with coef_we high stores coef_data into the coefficient chosen by coef_sel: 0 = start phase, 1 = start frequency, 2 = start chirp rate, 3 = cubic increment.
- R3: A start pulse while idle with a nonzero sample_count makes busy and phase_valid high from the next cycle. In that cycle, phase_out equals the top OUT_W bits of the start phase. A start phase of 0xC000000000000 gives 0xC000.
- R4: In the k-th valid cycle (k from 0), phase_out equals the top OUT_W bits of (P + k*F + k(k-1)/2*R + k(k-1)(k-2)/6*C) mod 2^ACC_W, where P, F, R and C are the start phase, start frequency, start chirp rate and cubic increment.
- R5: A chirp yields exactly sample_count consecutive valid cycles. busy equals phase_valid throughout, and both fall together after the last sample.
- R6: Phase sums wrap modulo 2^ACC_W with no saturation. For example, a start phase of all ones with a frequency of 1 gives phase_out 0 at k = 1.
- R7: While idle, phase_valid stays low and phase_out holds. After a chirp of N samples, it holds the R4 value for k = N.
- R8: A coefficient write while busy is dropped. The following chirp uses the coefficients that were stored before it.
- R9: A start pulse while busy does not change the current chirp length. A start pulse with sample_count zero leaves the block idle.
- R10: Coefficients persist across chirps. A second start without new writes repeats the same phase sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 2 | Coefficient index (0 phase, 1 frequency, 2 rate, 3 cubic) |
| coef_data | input | ACC_W (52) | Coefficient value, scaled by 2^ACC_W |
| start | input | 1 | Chirp start strobe |
| sample_count | input | CNT_W (16) | Number of samples, captured at start |
| busy | output | 1 | High while a chirp is running |
| phase_valid | output | 1 | phase_out carries a chirp sample |
| phase_out | output | OUT_W (16) | Truncated upper bits of the phase register |

## Verification
Each section integrates the one inside it. A wrong value in the chirp-rate or cubic path therefore does not show at the first output. It appears as a phase deviation that grows quadratically or cubically with the sample index, so long random chirps are needed, and the last sample shows the largest deviation. A wrong start phase or frequency shows at the first or second valid sample. A counter error shows as a valid window one cycle too long or too short, seen at the falling edge of busy. A dropped coefficient lock shows only on the chirp after the offending write.

// File: rtl/cubic_phase_pkg.sv
package cubic_phase_pkg;

    typedef enum logic [1:0] {
        COEF_PHASE = 2'd0,
        COEF_FREQ  = 2'd1,
        COEF_RATE  = 2'd2,
        COEF_CUBIC = 2'd3
    } coef_idx_e;

    localparam int NUM_COEF     = 4;
    localparam int NUM_SECTIONS = 3;

endpackage

// File: rtl/coef_bank.sv
module coef_bank #(
    parameter int W = 52
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_val,
    input  logic         lock,
    output logic [W-1:0] phase0,
    output logic [W-1:0] freq0,
    output logic [W-1:0] rate0,
    output logic [W-1:0] cubic
);
    import cubic_phase_pkg::*;

    typedef struct packed {
        logic [W-1:0] phase;
        logic [W-1:0] freq;
        logic [W-1:0] rate;
        logic [W-1:0] cubic;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en && !lock) begin
            unique case (coef_idx_e'(wr_sel))
                COEF_PHASE: bank_d.phase = wr_val;
                COEF_FREQ:  bank_d.freq  = wr_val;
                COEF_RATE:  bank_d.rate  = wr_val;
                COEF_CUBIC: bank_d.cubic = wr_val;
                default:    bank_d = bank_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign phase0 = bank_q.phase;
    assign freq0  = bank_q.freq;
    assign rate0  = bank_q.rate;
    assign cubic  = bank_q.cubic;
endmodule

// File: rtl/accum_section.sv
module accum_section #(
    parameter int W = 52
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] init_val,
    input  logic         step,
    input  logic [W-1:0] inc,
    output logic [W-1:0] acc
);
    typedef struct packed {
        logic [W-1:0] acc;
    } sect_t;

    sect_t sect_d, sect_q;

    always_comb begin
        sect_d = sect_q;
        if (load)      sect_d.acc = init_val;
        else if (step) sect_d.acc = sect_q.acc + inc;   // wraps mod 2^W
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sect_q <= '0;
        else        sect_q <= sect_d;
    end

    assign acc = sect_q.acc;
endmodule

// File: rtl/sample_sequencer.sv
module sample_sequencer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] count,
    output logic          load,
    output logic          step,
    output logic          busy
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] remain;
    } seq_t;

    seq_t seq_d, seq_q;
    logic accept;

    always_comb begin
        seq_d  = seq_q;
        accept = start && !seq_q.busy && (count != '0);
        if (accept) begin
            seq_d.busy   = 1'b1;
            seq_d.remain = count;
        end else if (seq_q.busy) begin
            seq_d.remain = seq_q.remain - 1'b1;
            if (seq_q.remain == CW'(1)) seq_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign load = accept;
    assign step = seq_q.busy;
    assign busy = seq_q.busy;
endmodule

// File: rtl/cubic_phase_gen.sv
module cubic_phase_gen #(
    parameter int ACC_W = 52,
    parameter int OUT_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             coef_we,
    input  logic [1:0]       coef_sel,
    input  logic [ACC_W-1:0] coef_data,
    input  logic             start,
    input  logic [CNT_W-1:0] sample_count,
    output logic             busy,
    output logic             phase_valid,
    output logic [OUT_W-1:0] phase_out
);
    import cubic_phase_pkg::*;

    localparam int TOP_BIT = ACC_W - 1;

    logic [ACC_W-1:0] k_phase, k_freq, k_rate, k_cubic;
    logic             seq_load, seq_step, seq_busy;
    logic [ACC_W-1:0] sec_acc  [NUM_SECTIONS];
    logic [ACC_W-1:0] sec_init [NUM_SECTIONS];
    logic [ACC_W-1:0] sec_inc  [NUM_SECTIONS];

    coef_bank #(.W(ACC_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (coef_we),
        .wr_sel (coef_sel),
        .wr_val (coef_data),
        .lock   (seq_busy),
        .phase0 (k_phase),
        .freq0  (k_freq),
        .rate0  (k_rate),
        .cubic  (k_cubic)
    );

    sample_sequencer #(.CW(CNT_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .count (sample_count),
        .load  (seq_load),
        .step  (seq_step),
        .busy  (seq_busy)
    );

    assign sec_init[0] = k_phase;
    assign sec_init[1] = k_freq;
    assign sec_init[2] = k_rate;

    // Section 0 is phase, 1 is frequency, 2 is chirp rate; each is fed by the next.
    for (genvar i = 0; i < NUM_SECTIONS; i++) begin : g_sect
        if (i == NUM_SECTIONS - 1) begin : g_inner
            assign sec_inc[i] = k_cubic;
        end else begin : g_outer
            assign sec_inc[i] = sec_acc[i+1];
        end

        accum_section #(.W(ACC_W)) u_sect (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (seq_load),
            .init_val (sec_init[i]),
            .step     (seq_step),
            .inc      (sec_inc[i]),
            .acc      (sec_acc[i])
        );
    end

    assign busy        = seq_busy;
    assign phase_valid = seq_busy;
    assign phase_out   = sec_acc[0][TOP_BIT -: OUT_W];
endmodule

// File: rtl/cubic_phase_chk.sv
module cubic_phase_chk #(
    parameter int OUT_W = 16,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] sample_count,
    input logic             busy,
    input logic             phase_valid,
    input logic [OUT_W-1:0] phase_out
);
    logic [CNT_W:0] run_len;
    logic [CNT_W:0] want_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len  <= '0;
            want_len <= '0;
        end else if (start && !busy && sample_count != '0) begin
            run_len  <= '0;
            want_len <= {1'b0, sample_count};
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end
    end

    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && sample_count != '0) |=> (busy && phase_valid));

    assert_zero_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && sample_count == '0) |=> !busy);

    assert_run_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == want_len));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(phase_out) && !phase_valid));

    assert_valid_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind cubic_phase_gen cubic_phase_chk #(.OUT_W(OUT_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .sample_count (sample_count),
    .busy         (busy),
    .phase_valid  (phase_valid),
    .phase_out    (phase_out)
);

// File: tb/tb_cubic_phase_gen.sv
module tb_cubic_phase_gen;
    localparam int ACC_W = 52;
    localparam int OUT_W = 16;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             coef_we = 1'b0;
    logic [1:0]       coef_sel = 2'd0;
    logic [ACC_W-1:0] coef_data = '0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] sample_count = '0;
    logic             busy, phase_valid;
    logic [OUT_W-1:0] phase_out;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [ACC_W-1:0] m [4];

    always #4 clk = ~clk;

    cubic_phase_gen #(.ACC_W(ACC_W), .OUT_W(OUT_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_sel(coef_sel),
        .coef_data(coef_data), .start(start), .sample_count(sample_count),
        .busy(busy), .phase_valid(phase_valid), .phase_out(phase_out)
    );

    function automatic logic [ACC_W-1:0] poly(input int k);
        logic [63:0] kk, c2, c3;
        logic [ACC_W-1:0] s;
        kk = 64'(k);
        c2 = (k >= 2) ? (kk * (kk - 64'd1)) / 64'd2 : 64'd0;
        c3 = (k >= 3) ? (kk * (kk - 64'd1) * (kk - 64'd2)) / 64'd6 : 64'd0;
        s = m[0] + kk[ACC_W-1:0] * m[1] + c2[ACC_W-1:0] * m[2] + c3[ACC_W-1:0] * m[3];
        return s;
    endfunction

    function automatic logic [OUT_W-1:0] top_of(input logic [ACC_W-1:0] v);
        return v[ACC_W-1 -: OUT_W];
    endfunction

    function automatic logic [ACC_W-1:0] rnd52();
        logic [63:0] r;
        r = {$urandom(), $urandom()};
        return r[ACC_W-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic [ACC_W-1:0] val);
        @(negedge clk);
        coef_we = 1'b1; coef_sel = 2'(idx); coef_data = val;
        @(negedge clk);
        coef_we = 1'b0;
        m[idx] = val;
    endtask

    // inj_kind: 1 = coefficient write during chirp, 2 = start pulse during chirp
    task automatic run_chirp(input int n, input int inj_k, input int inj_kind, input string req);
        bit seq_ok = 1'b1;
        logic [OUT_W-1:0] bad_act = '0, bad_exp = '0;
        @(negedge clk);
        start = 1'b1; sample_count = CNT_W'(n);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < n; k++) begin
            coef_we = 1'b0;
            start = 1'b0;
            if (k == 0)
                check(busy && phase_valid, "R3", "busy/valid after start", {62'd0, busy, phase_valid}, 64'd3);
            if (seq_ok && (!phase_valid || !busy || phase_out !== top_of(poly(k)))) begin
                seq_ok = 1'b0; bad_act = phase_out; bad_exp = top_of(poly(k));
                $display("  sample %0d mismatch", k);
            end
            if (k == inj_k && inj_kind == 1) begin
                coef_we = 1'b1; coef_sel = 2'd1; coef_data = rnd52();
            end
            if (k == inj_k && inj_kind == 2) begin
                start = 1'b1; sample_count = CNT_W'(n + 7);
            end
            @(negedge clk);
        end
        coef_we = 1'b0;
        start = 1'b0;
        check(seq_ok, req, "phase sequence", 64'(bad_act), 64'(bad_exp));
        check(!busy && !phase_valid, "R5", "valid falls after last sample", {62'd0, busy, phase_valid}, 64'd0);
        check(phase_out == top_of(poly(n)), "R7", "idle hold value", 64'(phase_out), 64'(top_of(poly(n))));
    endtask

    initial begin : watchdog
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++;
                tests++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("  [TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 4; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        check(!busy && !phase_valid && phase_out == '0, "R1", "reset state",
              {46'd0, busy, phase_valid, phase_out}, 64'd0);
        rst_n = 1'b1;

        // R3: three-quarter rotation start phase, flat frequency
        load(0, 52'hC000000000000);
        run_chirp(4, -1, 0, "R3");

        // R2: each coefficient alone lands at its own sample index
        load(0, 52'h0); load(1, 52'h123456789ABCD); run_chirp(3, -1, 0, "R2");
        load(1, 52'h0); load(2, 52'h0F0F0F0F0F0F0); run_chirp(4, -1, 0, "R2");
        load(2, 52'h0); load(3, 52'h0000ABCDE0000); run_chirp(6, -1, 0, "R2");

        // R6: wrap modulo full rotation
        load(0, 52'hFFFFFFFFFFFFF); load(1, 52'h1); load(2, 52'h0); load(3, 52'h0);
        run_chirp(2, -1, 0, "R6");
        load(0, 52'hF000000000000); load(1, 52'h4000000000000);
        load(2, 52'h8000000000000); load(3, 52'hFFFFFFFFF0000);
        run_chirp(40, -1, 0, "R6");

        // R4: random chirps
        for (int t = 0; t < 8; t++) begin
            for (int i = 0; i < 4; i++) load(i, rnd52());
            run_chirp(1 + int'($urandom_range(299)), -1, 0, "R4");
        end

        // R10: repeat without reload
        run_chirp(50, -1, 0, "R10");

        // R8: write during chirp dropped; next chirp uses stored values
        run_chirp(20, 5, 1, "R8");
        run_chirp(20, -1, 0, "R8");

        // R9: start during chirp does not alter its length
        run_chirp(15, 3, 2, "R9");

        // R9: zero count leaves block idle
        @(negedge clk);
        start = 1'b1; sample_count = '0;
        @(negedge clk);
        start = 1'b0;
        check(!busy && !phase_valid, "R9", "zero count stays idle", {62'd0, busy, phase_valid}, 64'd0);

        // R5: length at the boundary of one sample
        run_chirp(1, -1, 0, "R5");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule